// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block handles a page-mode DRAM's upkeep, apart from the normal read and write traffic. After reset it keeps every strobe inactive for a supply-settling delay. It then runs a fixed number of wake-up cycles that each contain a RAS pulse. Once those are done it raises `ready` and enters steady operation. In steady operation an interval timer posts one refresh demand per row slot, so the whole array is covered within the retention period. The default interval is 3125 clocks, which is 15.625 us at 200 MHz.

Every cycle this block issues is a CAS-before-RAS cycle. The device's own row counter picks the row, so the sequencer drives no address. It takes the bus through a request/grant pair shared with the access controller, and it moves its strobes only while the grant is held. When the grant is late, demands pile up in a small counter and are then served back to back. A demand that arrives while the counter is full is lost, and a sticky overflow flag records the loss.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is low, and for at least PWRUP_CYCLES clocks after its release, `ras_n`, `cas_lo_n` and `cas_hi_n` stay high and `bus_req` and `ready` stay low.
- R2: After the wait, exactly INIT_CYCLES cycles run with `ready` low. `ready` goes high on the clock after the precharge of the last one ends, and it then stays high until reset.
- R3: In each cycle both CAS lines fall together. RAS falls after exactly CAS_SETUP clocks of CAS low, stays low exactly RAS_PULSE clocks, and rises in the same clock as both CAS lines. RAS is never low while CAS is high.
- R4: Between cycles all strobes stay high for at least PRECHARGE clocks. When the next cycle follows without a gap in the request/grant, they stay high for exactly PRECHARGE clocks.
- R5: `we_n` is high at all times.
- R6: A strobe is low only while `bus_gnt` is high. `bus_req` stays high while work is pending and drops once the sequencer is idle.
- R7: Once `ready` is high, one refresh demand is posted every REF_INTERVAL clocks. With the grant given at once, successive RAS falling edges are exactly REF_INTERVAL clocks apart.
- R8: Demands that cannot be served are counted up to BACKLOG_MAX. When the grant arrives, each counted demand gets one cycle, back to back, and no more cycles follow.
- R9: A demand that arrives while BACKLOG_MAX are already waiting is dropped and sets `backlog_ovf`. The flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_gnt | input | 1 | Access controller hands the DRAM strobes to this block |
| bus_req | output | 1 | Request for the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Low-byte column strobe, active low |
| cas_hi_n | output | 1 | High-byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| ready | output | 1 | Power-up sequence complete |
| backlog_ovf | output | 1 | Sticky: a refresh demand was lost |

## Verification
A phase counter loaded with the wrong value shows up within one cycle as a wrong CAS setup, RAS width or precharge gap, measured edge to edge at the strobes. A wrong wake-up count, or a `ready` update on the wrong clock, shows at the first rise of `ready`, which is compared with the number of completed RAS pulses. A backlog counter that saturates wrongly or decrements wrongly shows once the grant returns, as one cycle too many or too few, or as a wrong overflow flag. An interval timer that is off by even one clock moves the next RAS falling edge by that amount.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PWRUP_CYCLES = 40,
  parameter int INIT_CYCLES  = 8,
  parameter int REF_INTERVAL = 3125,
  parameter int CAS_SETUP    = 2,
  parameter int RAS_PULSE    = 7,
  parameter int PRECHARGE    = 5,
  parameter int BACKLOG_MAX  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_gnt,
  output logic bus_req,
  output logic ras_n,
  output logic cas_lo_n,
  output logic cas_hi_n,
  output logic we_n,
  output logic ready,
  output logic backlog_ovf
);

  localparam int PHASE_W = $clog2(PWRUP_CYCLES + CAS_SETUP + RAS_PULSE + PRECHARGE + 1);
  localparam int TICK_W  = $clog2(REF_INTERVAL + 1);
  localparam int INIT_W  = $clog2(INIT_CYCLES + 1);
  localparam int PEND_W  = $clog2(BACKLOG_MAX + 1);

  localparam logic [PHASE_W-1:0] PWR_LD   = PHASE_W'(PWRUP_CYCLES - 1);
  localparam logic [PHASE_W-1:0] SETUP_LD = PHASE_W'(CAS_SETUP - 1);
  localparam logic [PHASE_W-1:0] PULSE_LD = PHASE_W'(RAS_PULSE - 1);
  localparam logic [PHASE_W-1:0] PRE_LD   = PHASE_W'(PRECHARGE - 1);
  localparam logic [TICK_W-1:0]  TICK_LAST = TICK_W'(REF_INTERVAL - 1);
  localparam logic [INIT_W-1:0]  INIT_LD  = INIT_W'(INIT_CYCLES);
  localparam logic [PEND_W-1:0]  PEND_MAX = PEND_W'(BACKLOG_MAX);

  typedef enum logic [2:0] {S_PWR, S_IDLE, S_REQ, S_CAS, S_RAS, S_PRE} state_t;

  state_t              state;
  logic [PHASE_W-1:0]  phase;
  logic [INIT_W-1:0]   init_left;
  logic [PEND_W-1:0]   pend;
  logic [TICK_W-1:0]   tick_cnt;

  logic work, tick, phase_end, start, take_init, take_ref;

  assign work      = (init_left != '0) || (pend != '0);
  assign tick      = ready && (tick_cnt == TICK_LAST);
  assign phase_end = (phase == '0);
  assign start     = bus_gnt && ((state == S_REQ) || (state == S_PRE && phase_end && work));
  assign take_init = start && (init_left != '0);
  assign take_ref  = start && (init_left == '0);

  assign bus_req  = (state != S_PWR) && (state != S_IDLE);
  assign cas_lo_n = !((state == S_CAS) || (state == S_RAS));
  assign cas_hi_n = !((state == S_CAS) || (state == S_RAS));
  assign ras_n    = !(state == S_RAS);
  assign we_n     = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_PWR;
      phase <= PWR_LD;
      ready <= 1'b0;
    end else begin
      unique case (state)
        S_PWR: begin
          if (phase_end) state <= S_REQ;
          else phase <= phase - 1'b1;
        end
        S_IDLE: if (work) state <= S_REQ;
        S_REQ: begin
          if (bus_gnt) begin
            state <= S_CAS;
            phase <= SETUP_LD;
          end
        end
        S_CAS: begin
          if (phase_end) begin
            state <= S_RAS;
            phase <= PULSE_LD;
          end else phase <= phase - 1'b1;
        end
        S_RAS: begin
          if (phase_end) begin
            state <= S_PRE;
            phase <= PRE_LD;
          end else phase <= phase - 1'b1;
        end
        S_PRE: begin
          if (phase_end) begin
            if (init_left == '0) ready <= 1'b1;
            if (!work) state <= S_IDLE;
            else if (bus_gnt) begin
              state <= S_CAS;
              phase <= SETUP_LD;
            end else state <= S_REQ;
          end else phase <= phase - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_left <= INIT_LD;
    else if (take_init) init_left <= init_left - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_cnt <= '0;
    else if (!ready || tick) tick_cnt <= '0;
    else tick_cnt <= tick_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend        <= '0;
      backlog_ovf <= 1'b0;
    end else if (tick && !take_ref) begin
      if (pend == PEND_MAX) backlog_ovf <= 1'b1;
      else pend <= pend + 1'b1;
    end else if (!tick && take_ref) begin
      pend <= pend - 1'b1;
    end
  end

  // R1
  pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PWR) |-> (ras_n && cas_lo_n && cas_hi_n && !bus_req && !ready));

  // R2
  ready_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (init_left == '0));

  // R3
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_lo_n && !cas_hi_n));

  // R6
  no_grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_REQ && !bus_gnt) |=> (ras_n && cas_lo_n && cas_hi_n));

  // R8
  backlog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PEND_MAX);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    backlog_ovf |=> backlog_ovf);

endmodule

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;
  localparam int PWR = 40, INIT = 8, RI = 100, SETUP = 2, PULSE = 6, PRE = 4, BLOG = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt_en = 1'b1;
  logic bus_gnt, bus_req, ras_n, cas_lo_n, cas_hi_n, we_n, ready, backlog_ovf;

  always #2.5 clk = ~clk;
  assign bus_gnt = gnt_en & bus_req;

  dram_refresh_seq #(.PWRUP_CYCLES(PWR), .INIT_CYCLES(INIT), .REF_INTERVAL(RI),
    .CAS_SETUP(SETUP), .RAS_PULSE(PULSE), .PRECHARGE(PRE), .BACKLOG_MAX(BLOG)) u_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req), .ras_n(ras_n),
    .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n), .we_n(we_n), .ready(ready), .backlog_ovf(backlog_ovf));

  int vectors = 0, miscompares = 0;
  int exp_q[$];
  int fall_stamp[$];
  int cyc = 0, all_hi = 0, setup_c = 0, width_c = 0, ncas = 0, nrise = 0;
  bit ras_p = 1, cas_p = 1, ready_p = 0, link = 0, ready_at_fall = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_cycles(input int kind, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(kind);
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(we_n === 1'b1, "R5", "we_n", int'(we_n), 1);
      chk(cas_lo_n === cas_hi_n, "R3", "cas lines equal", int'(cas_lo_n), int'(cas_hi_n));
      if (!ras_n || !cas_lo_n) chk(bus_gnt, "R6", "strobe without grant", int'(bus_gnt), 1);
      if (!ras_n) chk(!cas_lo_n, "R3", "ras low with cas high", int'(cas_lo_n), 0);
      if (cas_p && !cas_lo_n) begin
        if (ncas == 0) chk(all_hi >= PWR, "R1", "power-up gap", all_hi, PWR);
        else if (link) chk(all_hi == PRE, "R4", "back-to-back precharge", all_hi, PRE);
        else chk(all_hi >= PRE, "R4", "precharge", all_hi, PRE);
        ncas++;
      end
      if (ras_p && !ras_n) begin
        chk(setup_c == SETUP, "R3", "cas setup", setup_c, SETUP);
        ready_at_fall = ready;
        fall_stamp.push_back(cyc);
      end
      if (!ras_p && ras_n) begin
        chk(width_c == PULSE, "R3", "ras width", width_c, PULSE);
        chk(cas_lo_n && cas_hi_n, "R3", "cas rise with ras", int'(cas_lo_n), 1);
        if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected cycle", nrise, -1);
        else begin
          int k;
          k = exp_q.pop_front();
          chk(int'(ready_at_fall) == k, "R2", "cycle kind (ready at ras fall)", int'(ready_at_fall), k);
        end
        nrise++;
        link = 1;
      end
      if (!ready_p && ready) begin
        chk(nrise == INIT, "R2", "pulses before ready", nrise, INIT);
        chk(all_hi == PRE, "R2", "ready after last precharge", all_hi, PRE);
      end
      if (ready_p && !ready) chk(1'b0, "R2", "ready dropped", 0, 1);
      all_hi  = (ras_n && cas_lo_n) ? all_hi + 1 : 0;
      setup_c = (!cas_lo_n && ras_n) ? setup_c + 1 : 0;
      width_c = (!ras_n) ? width_c + 1 : 0;
      if (!(bus_req && bus_gnt)) link = 0;
      ras_p = ras_n; cas_p = cas_lo_n; ready_p = ready;
      cyc++;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(ras_n && cas_lo_n && cas_hi_n, "R1", "strobes in reset", int'(ras_n), 1);
    chk(!bus_req, "R1", "bus_req in reset", int'(bus_req), 0);
    chk(!ready && !backlog_ovf, "R1", "ready/ovf in reset", int'(ready), 0);
    expect_cycles(0, INIT);
    rst_n = 1'b1;
    repeat (PWR - 5) @(negedge clk);
    chk(!bus_req && !ready, "R1", "quiet during power-up wait", int'(bus_req), 0);
    while (!ready) @(negedge clk);
    wait_drain();

    fall_stamp.delete();
    expect_cycles(1, 3);
    wait_drain();
    chk(fall_stamp.size() == 3, "R7", "refresh count", fall_stamp.size(), 3);
    if (fall_stamp.size() == 3) begin
      chk(fall_stamp[1] - fall_stamp[0] == RI, "R7", "interval 1", fall_stamp[1] - fall_stamp[0], RI);
      chk(fall_stamp[2] - fall_stamp[1] == RI, "R7", "interval 2", fall_stamp[2] - fall_stamp[1], RI);
    end
    repeat (PRE + 3) @(negedge clk);
    chk(!bus_req, "R6", "bus_req drops when idle", int'(bus_req), 0);

    expect_cycles(1, 1);
    wait_drain();
    gnt_en = 1'b0;
    repeat (2 * RI + RI / 2) @(negedge clk);
    chk(bus_req, "R6", "request held while pending", int'(bus_req), 1);
    chk(ras_n && cas_lo_n, "R6", "strobes idle without grant", int'(ras_n), 1);
    expect_cycles(1, 2);
    gnt_en = 1'b1;
    wait_drain();
    chk(!backlog_ovf, "R9", "no overflow within backlog", int'(backlog_ovf), 0);

    expect_cycles(1, 1);
    wait_drain();
    gnt_en = 1'b0;
    repeat (4 * RI + RI / 5) @(negedge clk);
    chk(backlog_ovf, "R9", "overflow raised", int'(backlog_ovf), 1);
    expect_cycles(1, BLOG);
    gnt_en = 1'b1;
    wait_drain();
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "queue drained", exp_q.size(), 0);
    chk(!bus_req, "R8", "no extra cycle after backlog", int'(bus_req), 0);
    chk(backlog_ovf, "R9", "overflow sticky", int'(backlog_ovf), 1);
    finish_run();
  end
endmodule